// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a small processor with a single accumulator. It runs every instruction as a chain of single register transfers, one per clock. The architectural registers are a program counter, a memory address register, a memory data register, an instruction register and the accumulator. A controller steps them through fetch, decode and execute. The block talks to one shared synchronous memory through a 12-bit address bus, a 16-bit write data path, a 16-bit read data path, and separate read and write strobes.

An instruction word is 16 bits wide. The opcode sits in the four upper bits and an operand address in the twelve lower bits. There are six defined operations: load, store, add, subtract, jump and halt. Memory answers a read one cycle after the read strobe, so a read and the capture of its data always fall in two consecutive cycles.

Top module: `accSeqCpu`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, including the accumulator. Outputs while in reset: both strobes low and `halted` low. The first cycle after reset is released starts a fetch, and that fetch reads address 0.
- R2: A fetch plus decode takes five cycles. The read strobe is high only in the second of them. The other four drive neither strobe.
- R3: The fetch read puts the program counter on `memAddr`. After each fetched instruction the counter moves up by exactly one, wrapping from 0xFFF to 0x000.
- R4: Opcode encodings, taken from bits 15:12 of the instruction word: halt = 0, load = 1, store = 2, add = 3, subtract = 4, jump = 5. Bits 11:0 hold the operand address.
- R5: A load spends four execute cycles. The read strobe is high in the second of them, with the operand on `memAddr`. The accumulator then takes the word that was read.
- R6: A store spends two execute cycles. `memWrite` is high in the second, with the operand on `memAddr` and the accumulator on `memWdata`. The read and write strobes are never high together.
- R7: Add and subtract follow the same four-cycle read pattern as a load. They leave the accumulator plus or minus the word read, modulo 2^16.
- R8: A jump spends one execute cycle with no memory access. The next fetch reads from the operand address.
- R9: Halt raises `halted` in the cycle after decode. After that, `halted` stays high and both strobes stay low until reset, whatever the operand bits hold.
- R10: Opcodes 6 to 15 act as no-operations. The next fetch starts right after decode.
- R11: Read data is captured into the data register in the cycle after the one in which the read strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address, driven from the address register |
| memRead | output | 1 | Read strobe |
| memWrite | output | 1 | Write strobe |
| memWdata | output | 16 | Write data, driven from the accumulator |
| memRdata | input | 16 | Read data, valid one cycle after the read strobe |
| halted | output | 1 | High while parked in the halt state |

## Verification
Three programs run, each against an instruction-level model in the bench that predicts the strobes, address and write data for every cycle.

- **Arithmetic program.** Loads, adds, subtracts and stores values chosen to wrap at both ends of the 16-bit range. It separates correct modulo arithmetic from a wrong carry or borrow, and checks that halt ignores its operand bits.
- **Control-flow program.** Begins by storing the accumulator straight after reset, then jumps over a store that must never appear, then runs two undefined opcodes. It separates a cleared accumulator, a jump that really loads the program counter, and a no-operation that really skips the execute steps.
- **Wrap program.** Jumps to the top address, so the program counter wraps to zero. It then fetches an instruction that the program itself just wrote. This ties counter wrap-around to read-after-write through memory.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HLT = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDA = 4'd1;
  localparam logic [OPC_W-1:0] OP_STA = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB = 4'd4;
  localparam logic [OPC_W-1:0] OP_JMP = 4'd5;

  typedef enum logic [1:0] {
    ACC_PASS,
    ACC_ADD,
    ACC_SUB
  } accOpE;

  // Register-transfer strobes from the controller to the datapath
  typedef struct packed {
    logic  marFromPc;
    logic  marFromOpnd;
    logic  mdrLoad;
    logic  cirLoad;
    logic  pcInc;
    logic  pcJump;
    logic  accLoad;
    accOpE accOp;
  } ctrlStrobesT;

  typedef enum logic [3:0] {
    S_FETCH_ADDR,
    S_FETCH_READ,
    S_FETCH_MDR,
    S_FETCH_CIR,
    S_DECODE,
    S_EX_ADDR,
    S_EX_READ,
    S_EX_MDR,
    S_EX_ACC,
    S_EX_WRITE,
    S_EX_JUMP,
    S_HALT
  } seqStateE;

endpackage

// File: rtl/accCpuCtrl.sv
module accCpuCtrl
  import accCpuPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobesT      stb,
  output logic             memRead,
  output logic             memWrite,
  output logic             halted
);

  seqStateE state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH_ADDR;
    else     state <= nextState;
  end

  always_comb begin
    stb       = '0;
    memRead   = 1'b0;
    memWrite  = 1'b0;
    nextState = state;
    unique case (state)
      S_FETCH_ADDR: begin
        stb.marFromPc = 1'b1;
        nextState     = S_FETCH_READ;
      end
      S_FETCH_READ: begin
        memRead   = 1'b1;
        nextState = S_FETCH_MDR;
      end
      S_FETCH_MDR: begin
        stb.mdrLoad = 1'b1;
        nextState   = S_FETCH_CIR;
      end
      S_FETCH_CIR: begin
        stb.cirLoad = 1'b1;
        stb.pcInc   = 1'b1;
        nextState   = S_DECODE;
      end
      S_DECODE: begin
        case (opcode)
          OP_LDA, OP_STA, OP_ADD, OP_SUB: nextState = S_EX_ADDR;
          OP_JMP:                         nextState = S_EX_JUMP;
          OP_HLT:                         nextState = S_HALT;
          default:                        nextState = S_FETCH_ADDR;
        endcase
      end
      S_EX_ADDR: begin
        stb.marFromOpnd = 1'b1;
        nextState       = (opcode == OP_STA) ? S_EX_WRITE : S_EX_READ;
      end
      S_EX_READ: begin
        memRead   = 1'b1;
        nextState = S_EX_MDR;
      end
      S_EX_MDR: begin
        stb.mdrLoad = 1'b1;
        nextState   = S_EX_ACC;
      end
      S_EX_ACC: begin
        stb.accLoad = 1'b1;
        case (opcode)
          OP_ADD:  stb.accOp = ACC_ADD;
          OP_SUB:  stb.accOp = ACC_SUB;
          default: stb.accOp = ACC_PASS;
        endcase
        nextState = S_FETCH_ADDR;
      end
      S_EX_WRITE: begin
        memWrite  = 1'b1;
        nextState = S_FETCH_ADDR;
      end
      S_EX_JUMP: begin
        stb.pcJump = 1'b1;
        nextState  = S_FETCH_ADDR;
      end
      S_HALT:  nextState = S_HALT;
      default: nextState = S_FETCH_ADDR;
    endcase
  end

  assign halted = (state == S_HALT);

  // R6
  read_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !memRead && !memWrite);

  // R11
  read_then_capture_chk: assert property (@(posedge clk) disable iff (rst)
    memRead |=> stb.mdrLoad);

endmodule

// File: rtl/accCpuDatapath.sv
module accCpuDatapath
  import accCpuPkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobesT       stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc;
  logic [ADDR_W-1:0] operand;

  assign operand = cir[ADDR_W-1:0];
  assign opcode  = cir[DATA_W-1 -: OPC_W];

  // Program counter
  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (stb.pcJump) pc <= operand;
    else if (stb.pcInc)  pc <= pc + 1'b1;
  end

  // Address register
  always_ff @(posedge clk) begin
    if (rst)                  mar <= '0;
    else if (stb.marFromPc)   mar <= pc;
    else if (stb.marFromOpnd) mar <= operand;
  end

  // Data and instruction registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mdr <= '0;
      cir <= '0;
    end else begin
      if (stb.mdrLoad) mdr <= memRdata;
      if (stb.cirLoad) cir <= mdr;
    end
  end

  // Accumulator
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (stb.accLoad) begin
      case (stb.accOp)
        ACC_ADD: acc <= acc + mdr;
        ACC_SUB: acc <= acc - mdr;
        default: acc <= mdr;
      endcase
    end
  end

  assign memAddr  = mar;
  assign memWdata = acc;

  // R3
  pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
    stb.pcInc && !stb.pcJump |=> pc == $past(pc) + 1'b1);

  // R2
  mar_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
    stb.marFromPc |=> mar == $past(pc));

  // R11
  mdr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    stb.mdrLoad |=> mdr == $past(memRdata));

endmodule

// File: rtl/accSeqCpu.sv
module accSeqCpu
  import accCpuPkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted
);

  ctrlStrobesT      stb;
  logic [OPC_W-1:0] opcode;

  accCpuCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .stb      (stb),
    .memRead  (memRead),
    .memWrite (memWrite),
    .halted   (halted)
  );

  accCpuDatapath #(.ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .memRdata (memRdata),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: tb/accSeqCpu_test.sv
module accSeqCpu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic        memRead, memWrite, halted;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  logic [15:0] mem      [4096];
  logic [15:0] modelMem [4096];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit          rd;
    bit          wr;
    bit          hlt;
    logic [11:0] addr;
    logic [15:0] wd;
    string       tag;
  } expT;

  expT expQ[$];

  always #5 clk = ~clk;

  accSeqCpu uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata),
    .halted(halted)
  );

  // Synchronous memory: data valid one cycle after the read strobe
  always @(posedge clk) begin
    if (memRead)  memRdata <= mem[memAddr];
    if (memWrite) mem[memAddr] <= memWdata;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual %0d cycles, expected finish", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pushE(bit rd, bit wr, bit hlt, logic [11:0] a, logic [15:0] d, string tag);
    expT e;
    e.rd = rd; e.wr = wr; e.hlt = hlt; e.addr = a; e.wd = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      modelMem[i] = '0;
    end
  endtask

  task automatic putWord(int a, logic [15:0] w);
    mem[a] = w;
    modelMem[a] = w;
  endtask

  // Instruction-level model producing the expected port trace per cycle
  task automatic buildTrace();
    logic [11:0] pc = '0;
    logic [15:0] acc = '0;
    logic [15:0] ins;
    logic [11:0] opnd;
    string prev = "R1";
    expQ.delete();
    for (int n = 0; n < 300; n++) begin
      ins  = modelMem[pc];
      opnd = ins[11:0];
      pushE(0, 0, 0, 0, 0, {prev, " R2"});
      pushE(1, 0, 0, pc, 0, {prev, " R2 R3"});
      pushE(0, 0, 0, 0, 0, {prev, " R2"});
      pushE(0, 0, 0, 0, 0, {prev, " R2"});
      pushE(0, 0, 0, 0, 0, {prev, " R2 R4"});
      pc = pc + 1'b1;
      case (ins[15:12])
        4'd1, 4'd3, 4'd4: begin
          pushE(0, 0, 0, 0, 0, "R4 R5 R7");
          pushE(1, 0, 0, opnd, 0, "R5 R7 R11");
          pushE(0, 0, 0, 0, 0, "R5 R7");
          pushE(0, 0, 0, 0, 0, "R5 R7");
          if (ins[15:12] == 4'd1)      acc = modelMem[opnd];
          else if (ins[15:12] == 4'd3) acc = acc + modelMem[opnd];
          else                         acc = acc - modelMem[opnd];
          prev = "R5 R7";
        end
        4'd2: begin
          pushE(0, 0, 0, 0, 0, "R4 R6");
          pushE(0, 1, 0, opnd, acc, "R6 R5 R7");
          modelMem[opnd] = acc;
          prev = "R6";
        end
        4'd5: begin
          pushE(0, 0, 0, 0, 0, "R8");
          pc = opnd;
          prev = "R8";
        end
        4'd0: begin
          for (int k = 0; k < 8; k++) pushE(0, 0, 1, 0, 0, "R9");
          return;
        end
        default: prev = "R10";
      endcase
    end
  endtask

  task automatic runProgram(string name);
    int bad;
    expT e;
    buildTrace();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (memRead !== 1'b0 || memWrite !== 1'b0 || halted !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s reset: actual rd=%b wr=%b hlt=%b, expected 0 0 0",
               name, memRead, memWrite, halted);
    end
    rst = 1'b0;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      checks++;
      if (memRead !== e.rd || memWrite !== e.wr || halted !== e.hlt ||
          ((e.rd || e.wr) && memAddr !== e.addr) ||
          (e.wr && memWdata !== e.wd)) begin
        errors++;
        $display("FAIL %s (%s): actual rd=%b wr=%b hlt=%b addr=%h wd=%h, expected rd=%b wr=%b hlt=%b addr=%h wd=%h",
                 e.tag, name, memRead, memWrite, halted, memAddr, memWdata,
                 e.rd, e.wr, e.hlt, e.addr, e.wd);
      end
      @(negedge clk);
    end
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== modelMem[i]) bad++;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R6 %s memory image: actual %0d differing words, expected 0", name, bad);
    end
  endtask

  initial begin
    clearMem();
    // Arithmetic: wrap on add and subtract, halt with nonzero operand (R7, R9)
    putWord(12'h000, 16'h1020); putWord(12'h001, 16'h3021);
    putWord(12'h002, 16'h2030); putWord(12'h003, 16'h4022);
    putWord(12'h004, 16'h2031); putWord(12'h005, 16'h1030);
    putWord(12'h006, 16'h3023); putWord(12'h007, 16'h2032);
    putWord(12'h008, 16'h0ABC);
    putWord(12'h020, 16'hFFFF); putWord(12'h021, 16'h0002);
    putWord(12'h022, 16'h0005); putWord(12'h023, 16'h1234);
    runProgram("arith");

    // Control flow: cleared ACC, jump skip, undefined opcodes (R1, R8, R10)
    clearMem();
    putWord(12'h000, 16'h2040); putWord(12'h001, 16'h5005);
    putWord(12'h002, 16'h2041); putWord(12'h005, 16'h6ABC);
    putWord(12'h006, 16'hF000); putWord(12'h007, 16'h1044);
    putWord(12'h008, 16'h4045); putWord(12'h009, 16'h2042);
    putWord(12'h00A, 16'h0000);
    putWord(12'h040, 16'h7777); putWord(12'h044, 16'h0003);
    putWord(12'h045, 16'h0008);
    runProgram("flow");

    // PC wrap and self-written halt word (R3, R6, R9)
    clearMem();
    putWord(12'h000, 16'h5FFE); putWord(12'hFFE, 16'h4050);
    putWord(12'hFFF, 16'h2000); putWord(12'h050, 16'h0000);
    runProgram("wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule